// File: doc/BRIEF.md
# Fan Tachometer Period Meter

This block times one revolution slice of a cooling fan. It watches up to `NCH` tachometer inputs, and on request it measures the spacing between two consecutive qualifying edges on one of them. The spacing is counted in ticks of a slow measurement clock. That clock is the block clock divided by 4, 16, 64 or 256, as chosen by a two-bit divide field. The finished count lands in a 32-bit status word together with a completion flag. Firmware turns the count into a rotation speed: it assumes two tach pulses per revolution and computes RPM = f_clk * 60 / (2 * count * divisor).

Firmware starts a measurement in two steps. It first clears the trigger vector, then sets the single bit of the channel it wants. Each channel has its own enable bit. A channel that never produces a second edge (a stalled fan) is caught by a window limit, counted in measurement ticks. When the window runs out, the block reports a count of zero as a valid result. The result and flag are plain status pins: they hold their value until the next accepted trigger, so there is no back-pressure to manage.

Top module: `fan_tach_meter`

## Requirements
- R1: After reset, `done` is 0 and `result` is all zeros.
- R2: The measurement tick fires once every 4 << (2*`clk_div`) clock cycles: 4, 16, 64 or 256 for divide codes 0, 1, 2 and 3. A measurement restarts the divider.
- R3: A 0-to-1 change of bit n of `trigger`, with `chan_en[n]` set, starts a measurement on channel n. A trigger bit held at 1 starts nothing further. If several bits rise in the same cycle, the lowest index wins.
- R4: A rising trigger bit whose `chan_en` bit is 0 starts nothing. `done` and `result` keep their previous values.
- R5: Each tach input passes through a two-flop synchronizer before edge detection. `edge_mode` selects which edges qualify: 0 = falling only, 1 = rising only, 2 or 3 = both.
- R6: `result` bit 31 is the completion flag and equals `done`. Bits CNT_W-1:0 hold the count. All other bits are 0.
- R7: From the cycle after a measurement starts until it finishes, `done` is 0 and `result` reads as zero.
- R8: The count is the number of ticks that fire after the first qualifying edge and before the second. A tick in the same cycle as the second edge is not counted.
- R9: If the number of ticks since the start reaches `win_limit` (a limit of 0 acts as 1) without a second qualifying edge, the measurement ends with `done` = 1 and a count of 0. An edge in that same cycle takes precedence.
- R10: The count saturates at its all-ones value, 2^CNT_W - 1.
- R11: A new accepted trigger during a measurement abandons the current one and restarts on the newly selected channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tach_in | input | NCH | Raw tachometer inputs, asynchronous |
| chan_en | input | NCH | Per-channel enable |
| edge_mode | input | 2 | Qualifying edge select (0 fall, 1 rise, 2/3 both) |
| clk_div | input | 2 | Tick divide code, divisor 4 << (2*code) |
| trigger | input | NCH | One-hot start request, acts on 0-to-1 changes |
| win_limit | input | WIN_W | Window length in ticks |
| result | output | 32 | Flag in bit 31, count in bits CNT_W-1:0 |
| done | output | 1 | Measurement complete |

## Verification
The bench builds the meter with all 16 channels, a 16-bit window and a count width of only 6 bits. The narrow count lets a slow fan drive the counter into saturation within a few hundred clock cycles. At the full width of 20 bits, the 16-bit window would stop the measurement before saturation could happen. A short window on a stalled channel exercises the timeout path. The four divide codes, the three edge modes, retriggering and multi-bit triggers are all compared each cycle against a behavioural model. Range checks tie each count back to the tach period in clock cycles.

// File: rtl/fan_tach_pkg.sv
package fan_tach_pkg;

  typedef enum logic [1:0] {
    MS_IDLE  = 2'd0,
    MS_ARM   = 2'd1,
    MS_COUNT = 2'd2
  } meas_state_t;

  localparam logic [1:0] EDGE_FALL = 2'd0;
  localparam logic [1:0] EDGE_RISE = 2'd1;

  // Qualify one edge of a synchronized tach line against the mode code.
  function automatic logic edge_qualifies(logic [1:0] mode, logic prv, logic cur);
    case (mode)
      EDGE_FALL: return prv & ~cur;
      EDGE_RISE: return ~prv & cur;
      default:   return prv ^ cur;
    endcase
  endfunction

endpackage

// File: rtl/fan_tach_sync.sv
module fan_tach_sync #(
  parameter int NCH = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] raw_in,
  output logic [NCH-1:0] sync_cur,
  output logic [NCH-1:0] sync_prev
);

  for (genvar ch = 0; ch < NCH; ch++) begin : g_lane
    logic meta_q, stab_q, hist_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        stab_q <= 1'b0;
        hist_q <= 1'b0;
      end else begin
        meta_q <= raw_in[ch];
        stab_q <= meta_q;
        hist_q <= stab_q;
      end
    end
    assign sync_cur[ch]  = stab_q;
    assign sync_prev[ch] = hist_q;
  end

endmodule

// File: rtl/fan_tach_prescaler.sv
module fan_tach_prescaler #(
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [DIV_W-1:0] div_code,
  output logic             tick
);

  localparam int PRE_W = 2 + 2 * ((1 << DIV_W) - 1);

  logic [PRE_W-1:0] pcnt_q;
  logic [PRE_W-1:0] term;
  logic [PRE_W:0]   span;

  always_comb begin
    span = (PRE_W + 1)'(1) << (2 + 2 * int'(div_code));
    term = PRE_W'(span - 1'b1);
  end

  assign tick = (pcnt_q == term);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             pcnt_q <= '0;
    else if (restart|tick)  pcnt_q <= '0;
    else                    pcnt_q <= pcnt_q + 1'b1;
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R2

endmodule

// File: rtl/fan_tach_trigger.sv
module fan_tach_trigger #(
  parameter int NCH   = 16,
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   trigger,
  input  logic [NCH-1:0]   chan_en,
  output logic             start,
  output logic [SEL_W-1:0] start_sel
);

  logic [NCH-1:0] trig_q;
  logic [NCH-1:0] accepted;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_q <= '0;
    else        trig_q <= trigger;
  end

  assign accepted = trigger & ~trig_q & chan_en;
  assign start    = |accepted;

  // Lowest set index wins: scan downward so the last hit is the lowest.
  always_comb begin
    start_sel = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (accepted[i]) start_sel = SEL_W'(i);
    end
  end

endmodule

// File: rtl/fan_tach_meter.sv
module fan_tach_meter #(
  parameter int NCH   = 16,
  parameter int CNT_W = 20,
  parameter int WIN_W = 16,
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   tach_in,
  input  logic [NCH-1:0]   chan_en,
  input  logic [1:0]       edge_mode,
  input  logic [DIV_W-1:0] clk_div,
  input  logic [NCH-1:0]   trigger,
  input  logic [WIN_W-1:0] win_limit,
  output logic [31:0]      result,
  output logic             done
);
  import fan_tach_pkg::*;

  localparam int RES_W = 32;
  localparam int SEL_W = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int PAD_W = RES_W - 1 - CNT_W;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [NCH-1:0]   s_cur, s_prev;
  logic             tick, start;
  logic [SEL_W-1:0] start_sel, sel_q;
  meas_state_t      state_q;
  logic [WIN_W-1:0] win_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;
  logic             hit, expire;

  fan_tach_sync #(.NCH(NCH)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_in(tach_in),
    .sync_cur(s_cur), .sync_prev(s_prev)
  );

  fan_tach_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .restart(start),
    .div_code(clk_div), .tick(tick)
  );

  fan_tach_trigger #(.NCH(NCH), .SEL_W(SEL_W)) u_trig (
    .clk(clk), .rst_n(rst_n), .trigger(trigger), .chan_en(chan_en),
    .start(start), .start_sel(start_sel)
  );

  assign hit    = edge_qualifies(edge_mode, s_prev[sel_q], s_cur[sel_q]);
  assign expire = tick && ({1'b0, win_q} + 1'b1 >= {1'b0, win_limit});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= MS_IDLE;
      sel_q   <= '0;
      win_q   <= '0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else if (start) begin
      state_q <= MS_ARM;
      sel_q   <= start_sel;
      win_q   <= '0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      case (state_q)
        MS_ARM: begin
          if (hit) begin
            state_q <= MS_COUNT;
            cnt_q   <= '0;
            if (tick) win_q <= win_q + 1'b1;
          end else if (expire) begin
            state_q <= MS_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b1;
          end else if (tick) begin
            win_q <= win_q + 1'b1;
          end
        end
        MS_COUNT: begin
          if (hit) begin
            state_q <= MS_IDLE;
            done_q  <= 1'b1;
          end else if (expire) begin
            state_q <= MS_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b1;
          end else if (tick) begin
            win_q <= win_q + 1'b1;
            if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= MS_IDLE;
      endcase
    end
  end

  assign done   = done_q;
  assign result = {done_q, {PAD_W{1'b0}}, (done_q ? cnt_q : {CNT_W{1'b0}})};

  AST_START_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!done && result == '0)); // R7

  AST_TIMEOUT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != MS_IDLE && !start && !hit && expire)
      |=> (done && result[CNT_W-1:0] == '0)); // R9

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == MS_COUNT && cnt_q == CNT_MAX && tick && !hit && !expire && !start)
      |=> (cnt_q == CNT_MAX)); // R10

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (state_q == MS_IDLE)); // R7

endmodule

// File: tb/fan_tach_meter_tb_top.sv
module fan_tach_meter_tb_top;

  localparam int  NCH     = 16;
  localparam int  CNT_W   = 6;
  localparam int  WIN_W   = 16;
  localparam time CLK_PER = 10ns;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NCH-1:0]   tach_in = '0;
  logic [NCH-1:0]   chan_en = '0;
  logic [1:0]       edge_mode = 2'd1;
  logic [1:0]       clk_div = 2'd0;
  logic [NCH-1:0]   trigger = '0;
  logic [WIN_W-1:0] win_limit = 16'h1000;
  logic [31:0]      result;
  logic             done;

  fan_tach_meter #(.NCH(NCH), .CNT_W(CNT_W), .WIN_W(WIN_W), .DIV_W(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .tach_in(tach_in), .chan_en(chan_en),
    .edge_mode(edge_mode), .clk_div(clk_div), .trigger(trigger),
    .win_limit(win_limit), .result(result), .done(done)
  );

  always #(CLK_PER / 2) clk = ~clk;

  int    n_vec = 0, n_bad = 0, cyc = 0;
  bit    cmp_on = 0, finished = 0;
  string cur_req = "R1";

  // ---------- behavioural reference model ----------
  bit [NCH-1:0] m_s1, m_s2, m_s3, m_trigq;
  int m_state = 0, m_sel = 0, m_pcnt = 0, m_win = 0, m_cnt = 0;
  bit m_done = 0;

  function automatic bit [31:0] m_result();
    return m_done ? (32'h8000_0000 | 32'(m_cnt)) : 32'h0;
  endfunction

  task automatic model_step();
    bit tick, start, hit, expire, prv, cur;
    bit [NCH-1:0] acc;
    int pick;
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_s3 = '0; m_trigq = '0;
      m_state = 0; m_sel = 0; m_pcnt = 0; m_win = 0; m_cnt = 0; m_done = 0;
      return;
    end
    tick = (m_pcnt == ((4 << (2 * int'(clk_div))) - 1));
    acc = trigger & ~m_trigq & chan_en;
    start = (acc != 0);
    pick = 0;
    for (int i = NCH - 1; i >= 0; i--) if (acc[i]) pick = i;
    prv = m_s3[m_sel]; cur = m_s2[m_sel];
    case (edge_mode)
      2'd0: hit = prv && !cur;
      2'd1: hit = !prv && cur;
      default: hit = prv != cur;
    endcase
    expire = tick && (m_win + 1 >= int'(win_limit));
    m_s3 = m_s2; m_s2 = m_s1; m_s1 = tach_in; m_trigq = trigger;
    m_pcnt = (start || tick) ? 0 : m_pcnt + 1;
    if (start) begin
      m_state = 1; m_sel = pick; m_win = 0; m_cnt = 0; m_done = 0;
    end else if (m_state == 1) begin
      if (hit) begin m_state = 2; m_cnt = 0; if (tick) m_win++; end
      else if (expire) begin m_state = 0; m_cnt = 0; m_done = 1; end
      else if (tick) m_win++;
    end else if (m_state == 2) begin
      if (hit) begin m_state = 0; m_done = 1; end
      else if (expire) begin m_state = 0; m_cnt = 0; m_done = 1; end
      else if (tick) begin m_win++; if (m_cnt < (1 << CNT_W) - 1) m_cnt++; end
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cmp_on) begin
      n_vec++;
      if (result !== m_result() || done !== m_done) begin
        n_bad++;
        $display("FAIL %s cycle %0d: result=%h done=%b expected result=%h done=%b",
                 cur_req, cyc, result, done, m_result(), m_done);
      end
    end
    model_step();
    if (cyc == 3) cmp_on = 1;
  end

  // ---------- tach waveform generator ----------
  int half[NCH];
  int ph[NCH];
  initial begin
    for (int i = 0; i < NCH; i++) begin half[i] = 0; ph[i] = 0; end
    forever begin
      @(posedge clk); #1;
      for (int i = 0; i < NCH; i++) begin
        if (half[i] > 0) begin
          ph[i]++;
          if (ph[i] >= half[i]) begin ph[i] = 0; tach_in[i] = ~tach_in[i]; end
        end
      end
    end
  end

  // ---------- helpers ----------
  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_rng(string req, int act, int lo, int hi);
    n_vec++;
    if (act < lo || act > hi) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic step(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic fire(logic [NCH-1:0] mask);
    trigger = '0; step(2);
    trigger = mask; step(1);
  endtask

  task automatic wait_done(int lim);
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (done) return;
    end
  endtask

  // ---------- watchdog ----------
  initial begin
    #(CLK_PER * 150000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  // ---------- stimulus ----------
  logic [31:0] snap;
  initial begin
    step(4);
    cur_req = "R1";
    check("R1 reset result", result, 32'h0);
    check("R1 reset done", {31'b0, done}, 32'h1 & 32'h0);
    rst_n = 1'b1;
    chan_en = 16'hFFFB;
    half[0] = 20; half[3] = 50; half[5] = 7; half[9] = 400; half[10] = 600;
    step(30);

    cur_req = "R2";
    edge_mode = 2'd1; clk_div = 2'd0;
    fire(16'h0001);
    step(1);
    check("R7 busy reads zero", result, 32'h0);
    wait_done(400);
    check("R6 flag bit", {31'b0, result[31]}, 32'h1);
    check("R6 pad bits", {2'b0, result[30:CNT_W]}, 32'h0);
    check_rng("R2 R8 count div4 period40", int'(result[CNT_W-1:0]), 9, 11);

    cur_req = "R3";
    snap = result; step(60);
    check("R3 held trigger no restart", result, snap);

    cur_req = "R4";
    fire(16'h0004); step(60);
    check("R4 disabled channel ignored", result, snap);

    cur_req = "R5";
    edge_mode = 2'd0; clk_div = 2'd1;
    fire(16'h0008); wait_done(1500);
    check_rng("R5 falling div16 period100", int'(result[CNT_W-1:0]), 5, 7);
    edge_mode = 2'd2; clk_div = 2'd0;
    fire(16'h0020); wait_done(400);
    check_rng("R5 both edges half7", int'(result[CNT_W-1:0]), 1, 2);

    cur_req = "R2";
    edge_mode = 2'd1; clk_div = 2'd3;
    fire(16'h0400); wait_done(8000);
    check_rng("R2 div256 period1200", int'(result[CNT_W-1:0]), 3, 5);

    cur_req = "R9";
    clk_div = 2'd0; win_limit = 16'd20;
    fire(16'h0080); wait_done(300);
    check("R9 timeout zero count", result, 32'h8000_0000);

    cur_req = "R10";
    win_limit = 16'hFFFF;
    fire(16'h0200); wait_done(3000);
    check("R10 saturated count", result, 32'h8000_003F);

    cur_req = "R11";
    edge_mode = 2'd0; clk_div = 2'd1; win_limit = 16'h1000;
    fire(16'h0200); step(10);
    fire(16'h0028); wait_done(1500);
    check_rng("R11 R3 restart lowest index ch3", int'(result[CNT_W-1:0]), 5, 7);
    step(5);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule